// File: doc/BRIEF.md
# Radix-4 Recoded Sequential Multiplier

This block multiplies two unsigned N-bit operands and returns a 2N-bit product. Each iteration retires two bits of the multiplier. Every radix-4 multiplier digit is rewritten as a signed digit in the range -2..+2. The partial product for that digit is then the multiplicand, possibly doubled and possibly complemented, so no three-times multiple is ever formed. Partial products go into a pair of sum and carry vectors through a 3:2 compressor. No carry ripples until a single final addition turns the redundant pair into plain binary.

A caller presents both operands with a one-cycle start pulse while the block is idle. The block then stays busy for a fixed number of cycles and raises done for one cycle with the product valid. The product holds its value until the next operation completes. A start pulse that arrives while the block is busy is dropped.

Top module: `rmul_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, busy is 0, done is 0 and product is all zeros.
- R2: A start pulse sampled while idle raises busy from the next cycle. Done is high exactly ITER+1 clock edges after the edge that sampled start, where ITER = (N+3)/2 (9 for N=16).
- R3: Multiplier bit triples (b[2i+1], b[2i], b[2i-1]) with b[-1]=0 recode as follows: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, 101 and 110 give -1. The multiplier is zero-extended by two bits, so the last digit is never negative.
- R4: The product equals multiplicand times multiplier as unsigned values, exact in 2N bits, for every operand pair including 0, 1 and all ones.
- R5: Done lasts exactly one cycle, and busy is low whenever done is high.
- R6: A start pulse received while busy has no effect. The running operation completes at its original time with the product of its original operands.
- R7: The product output changes only in the cycle where done rises, and holds its value otherwise.
- R8: A negative digit contributes the ones' complement of its shifted multiple plus a +1 injected into bit 0 of the carry vector. One carry-propagating addition of the sum and carry vectors forms the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication (used only when idle) |
| multiplicand | input | N | Unsigned multiplicand |
| multiplier | input | N | Unsigned multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2N | Unsigned product, held between completions |

## Verification
The product and done are both due ITER+1 edges after the edge that samples start. Busy is due one edge after that sampling edge. Every check drives its inputs on the falling edge. It then counts falling edges from the start pulse: the first one checks busy, ITER later checks that done is still low, one more checks done and the product, and a final one checks that done has dropped and the product holds. Operands come from a table of corner values and from a random loop. The start-while-busy case reuses the same count to show that the completion cycle does not move.

// File: rtl/rmul_pkg.sv
package rmul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CONV = 2'd2
    } rmul_state_e;

    // Signed radix-4 digit: nz = nonzero, two = magnitude 2, neg = negative
    typedef struct packed {
        logic neg;
        logic two;
        logic nz;
    } rmul_digit_t;

endpackage

// File: rtl/rmul_recode.sv
module rmul_recode
    import rmul_pkg::*;
(
    input  logic [2:0]  trip,
    output rmul_digit_t dig
);

    always_comb begin
        dig = '0;
        unique case (trip)
            3'b001, 3'b010: dig = '{neg: 1'b0, two: 1'b0, nz: 1'b1};
            3'b011:         dig = '{neg: 1'b0, two: 1'b1, nz: 1'b1};
            3'b100:         dig = '{neg: 1'b1, two: 1'b1, nz: 1'b1};
            3'b101, 3'b110: dig = '{neg: 1'b1, two: 1'b0, nz: 1'b1};
            default:        dig = '0;
        endcase
    end

endmodule

// File: rtl/rmul_ppgen.sv
module rmul_ppgen
    import rmul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] mcand_sh,
    input  rmul_digit_t  dig,
    output logic [W-1:0] pp,
    output logic         cin
);

    logic [W-1:0] mag;

    always_comb begin
        if (!dig.nz)      mag = '0;
        else if (dig.two) mag = mcand_sh << 1;
        else              mag = mcand_sh;
        pp  = dig.neg ? ~mag : mag;
        cin = dig.neg;
    end

endmodule

// File: rtl/rmul_csa.sv
module rmul_csa #(
    parameter int W = 32
) (
    input  logic [W-1:0] sum_in,
    input  logic [W-1:0] carry_in,
    input  logic [W-1:0] addend,
    input  logic         cin,
    output logic [W-1:0] sum_out,
    output logic [W-1:0] carry_out
);

    logic [W-1:0] maj;

    always_comb begin
        sum_out   = sum_in ^ carry_in ^ addend;
        maj       = (sum_in & carry_in) | (sum_in & addend) | (carry_in & addend);
        carry_out = {maj[W-2:0], cin};
    end

endmodule

// File: rtl/rmul_top.sv
module rmul_top
    import rmul_pkg::*;
#(
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   multiplicand,
    input  logic [N-1:0]   multiplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);

    localparam int W    = 2 * N;
    localparam int ITER = (N + 3) / 2;
    localparam int CW   = $clog2(ITER + 1);
    localparam int MW   = N + 2;

    typedef struct packed {
        rmul_state_e     st;
        logic [CW-1:0]   cnt;
        logic [MW-1:0]   mplr;
        logic            prev;
        logic [W-1:0]    mcand;
        logic [W-1:0]    sum;
        logic [W-1:0]    carry;
        logic [W-1:0]    prod;
        logic            done;
    } rmul_regs_t;

    rmul_regs_t  r_q, r_d;
    rmul_digit_t dig;
    logic [W-1:0] pp;
    logic         pp_cin;
    logic [W-1:0] sum_nx, carry_nx;

    rmul_recode u_recode (
        .trip ({r_q.mplr[1:0], r_q.prev}),
        .dig  (dig)
    );

    rmul_ppgen #(.W(W)) u_ppgen (
        .mcand_sh (r_q.mcand),
        .dig      (dig),
        .pp       (pp),
        .cin      (pp_cin)
    );

    rmul_csa #(.W(W)) u_csa (
        .sum_in    (r_q.sum),
        .carry_in  (r_q.carry),
        .addend    (pp),
        .cin       (pp_cin),
        .sum_out   (sum_nx),
        .carry_out (carry_nx)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_RUN;
                    r_d.cnt   = CW'(ITER);
                    r_d.mplr  = {2'b00, multiplier};
                    r_d.prev  = 1'b0;
                    r_d.mcand = {{N{1'b0}}, multiplicand};
                    r_d.sum   = '0;
                    r_d.carry = '0;
                end
            end
            ST_RUN: begin
                r_d.sum   = sum_nx;
                r_d.carry = carry_nx;
                r_d.prev  = r_q.mplr[1];
                r_d.mplr  = r_q.mplr >> 2;
                r_d.mcand = r_q.mcand << 2;
                r_d.cnt   = r_q.cnt - 1'b1;
                if (r_q.cnt == CW'(1)) r_d.st = ST_CONV;
            end
            ST_CONV: begin
                r_d.prod = r_q.sum + r_q.carry;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign product = r_q.prod;

    AST_TOP_DIGIT_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && r_q.cnt == CW'(1)) |-> !dig.neg); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R5
    AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && r_q.cnt > CW'(1) && start) |=> (r_q.st == ST_RUN)); // R6
    AST_CONV_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CONV) |-> (r_q.mplr == '0 && !r_q.prev)); // R8

endmodule

// File: tb/tb_rmul_top.sv
module tb_rmul_top;

    localparam int N          = 16;
    localparam int ITER       = (N + 3) / 2;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;

    localparam logic [N-1:0] TA [NVEC] = '{16'h0000, 16'h0001, 16'hFFFF, 16'hFFFF, 16'h0001,
                                          16'h5555, 16'hAAAA, 16'h8000, 16'h1234, 16'hFFFE};
    localparam logic [N-1:0] TB [NVEC] = '{16'hFFFF, 16'h0001, 16'hFFFF, 16'h0000, 16'hFFFF,
                                          16'hAAAA, 16'h5555, 16'h8000, 16'h6789, 16'h7FFF};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   mc = '0;
    logic [N-1:0]   mp = '0;
    logic           busy, done;
    logic [2*N-1:0] product;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rmul_top #(.N(N)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (mc),
        .multiplier   (mp),
        .busy         (busy),
        .done         (done),
        .product      (product)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One operation; optional start pulse while busy with other operands (R6)
    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit poke);
        logic [2*N-1:0] exp;
        exp = {{N{1'b0}}, a} * {{N{1'b0}}, b};
        @(negedge clk);
        mc = a; mp = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", {63'd0, busy}, 64'd1);
        for (int i = 0; i < ITER; i++) begin
            if (poke && i == 2) begin
                mc = ~a; mp = b ^ 16'h00F0; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R2 done not early", {63'd0, done}, 64'd0);
        @(negedge clk);
        chk("R2 done on time", {63'd0, done}, 64'd1);
        chk("R5 busy low with done", {63'd0, busy}, 64'd0);
        chk(poke ? "R6 product of first operands" : "R4 product", {32'd0, product}, {32'd0, exp});
        @(negedge clk);
        chk("R5 done one cycle", {63'd0, done}, 64'd0);
        chk("R7 product held", {32'd0, product}, {32'd0, exp});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy in reset", {63'd0, busy}, 64'd0);
        chk("R1 done in reset", {63'd0, done}, 64'd0);
        chk("R1 product in reset", {32'd0, product}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {62'd0, busy, done}, 64'd0);

        // R4, R3, R8: table of corner vectors (all ones exercises negative digits)
        for (int v = 0; v < NVEC; v++) run_op(TA[v], TB[v], 1'b0);

        // R4: random operands
        for (int k = 0; k < 40; k++) run_op(N'($urandom), N'($urandom), 1'b0);

        // R6: start while busy is ignored
        run_op(16'hBEEF, 16'hC0DE, 1'b1);
        run_op(16'hFFFF, 16'h0003, 1'b1);

        // R7: product holds while idle with operands changing
        @(negedge clk);
        mc = 16'h1111; mp = 16'h2222;
        repeat (5) @(negedge clk);
        chk("R7 product idle hold", {32'd0, product}, {32'd0, 32'hFFFF * 32'h0003});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule